// File: doc/BRIEF.md
# Cache Lockdown Victim Selector

This block holds the replacement state for two set-associative caches, one for instructions and one for data. Each segment has 64 lines, and each cache has eight segments. For each cache it keeps a lockdown base index and one victim pointer per segment. When a linefill arrives for a segment, the block names the line that will be overwritten. It then advances that segment's pointer, either in round-robin order or in pseudo-random order, depending on a policy input. Lines whose index is below the base are never named, so they stay locked in the cache.

Software reaches the state through a register-style port. A select input picks the data-cache or the instruction-cache copy. A normal write loads the base and every victim pointer of the chosen cache at once. A debug write loads the victim pointer of one segment only. A read returns the base. The usual way to lock a line is to set the base to the target line, cause a linefill into it, and then raise the base past it.

Top module: `lockdown_victim_sel`

## Requirements
- R1: After reset, both bases and all sixteen victim pointers are 0. The first linefill of any segment names line 0, and a read returns 0.
- R2: `reg_rdata` is `{base, 26'b0}` for the cache chosen by `rd_sel` (0 = data, 1 = instruction). It shows the registered base, so a write is visible from the cycle after it.
- R3: A normal write (`reg_wr`=1, `reg_dbg`=0) loads `reg_wdata[31:26]` into the base and into all eight victim pointers of the cache chosen by `reg_sel` (0 = data, 1 = instruction). The other cache is unchanged.
- R4: While a fill strobe is high, the victim output combinationally shows the current pointer of the tagged segment. The pointer moves at the next clock edge.
- R5: With `rr_mode`=1, a fill advances the pointer by one, and a pointer of 63 goes back to the base.
- R6: With `rr_mode`=0, a fill moves the pointer to the low six bits of a free-running LFSR if that value is at or above the base. Otherwise it makes the round-robin step. The result always lies in [base, 63].
- R7: No victim output is ever below the base. A base of 0 leaves every line available.
- R8: A debug write (`reg_wr`=1, `reg_dbg`=1) loads `reg_wdata[31:26]` into the victim pointer of segment `reg_wdata[7:5]` only. A value below the base is raised to the base. The base and the other segments keep their values.
- R9: When a write and a fill of the same cache happen in the same cycle, the fill names the newly written value and the pointer advances from it.
- R10: A fill changes only the pointer of its own segment in its own cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 1 = round-robin advance, 0 = random advance |
| reg_wr | input | 1 | Register write strobe |
| reg_dbg | input | 1 | Write is the single-segment victim write |
| reg_sel | input | 1 | Write target: 0 data cache, 1 instruction cache |
| reg_wdata | input | 32 | Write data: index in [31:26], segment in [7:5] |
| rd_sel | input | 1 | Read target: 0 data cache, 1 instruction cache |
| reg_rdata | output | 32 | Base of the selected cache in [31:26], rest 0 |
| dfill | input | 1 | Data-cache linefill strobe |
| dfill_seg | input | 3 | Data-cache linefill segment |
| dvictim | output | 6 | Data-cache victim line for the current fill |
| ifill | input | 1 | Instruction-cache linefill strobe |
| ifill_seg | input | 3 | Instruction-cache linefill segment |
| ivictim | output | 6 | Instruction-cache victim line for the current fill |

## Verification
The victim outputs are combinational, so the bench checks them in the same cycle that the fill strobe is driven. Inputs change on the falling edge, and the check is made one nanosecond later. The pointer update belongs to the rising edge that follows, and it is seen at the next fill of that segment. The read port shows a register, so a base written in one cycle is checked only from the next cycle onward. During the write cycle itself the bench expects the old base. Random-mode fills cannot be predicted without copying the LFSR, so the bench checks each one against [base, 63] and adopts the observed value for later round-robin predictions.

// File: rtl/lockdown_pkg.sv
package lockdown_pkg;

  typedef enum logic {
    CSEL_DATA = 1'b0,
    CSEL_INST = 1'b1
  } cache_sel_e;

  localparam int NUM_CACHES = 2;

endpackage

// File: rtl/lockdown_lfsr.sv
module lockdown_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_o
);

  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = {1'b0, st_q[W-1:1]};
    if (st_q[0]) st_d = st_d ^ TAPS[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= W'(1);
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  assert_lfsr_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);

endmodule

// File: rtl/lockdown_ptr_bank.sv
module lockdown_ptr_bank #(
  parameter int IDX_W = 6,
  parameter int SEG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_mode_i,
  input  logic             wr_base_i,
  input  logic             wr_dbg_i,
  input  logic [IDX_W-1:0] wr_val_i,
  input  logic [SEG_W-1:0] wr_seg_i,
  input  logic             fill_i,
  input  logic [SEG_W-1:0] fill_seg_i,
  input  logic [IDX_W-1:0] rnd_i,
  output logic [IDX_W-1:0] base_o,
  output logic [IDX_W-1:0] victim_o
);

  localparam int               NSEG  = 1 << SEG_W;
  localparam logic [IDX_W-1:0] TOP_IX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] base_q, base_d;
  logic [IDX_W-1:0] vic_q   [NSEG];
  logic [IDX_W-1:0] vic_eff [NSEG];
  logic [IDX_W-1:0] vic_d   [NSEG];
  logic [NSEG-1:0]  vic_en;
  logic [IDX_W-1:0] dbg_val, cur, rr_step, rnd_pick, adv;

  // effective state after any same-cycle write (write beats fill)
  always_comb begin
    base_d  = wr_base_i ? wr_val_i : base_q;
    dbg_val = (wr_val_i < base_q) ? base_q : wr_val_i;
    for (int s = 0; s < NSEG; s++) begin
      if (wr_base_i)                                   vic_eff[s] = wr_val_i;
      else if (wr_dbg_i && wr_seg_i == SEG_W'(s))      vic_eff[s] = dbg_val;
      else                                             vic_eff[s] = vic_q[s];
    end
  end

  // advance of the filled segment
  always_comb begin
    cur      = vic_eff[fill_seg_i];
    rr_step  = (cur == TOP_IX || cur < base_d) ? base_d : cur + IDX_W'(1);
    rnd_pick = (rnd_i >= base_d) ? rnd_i : rr_step;
    adv      = rr_mode_i ? rr_step : rnd_pick;
  end

  always_comb begin
    for (int s = 0; s < NSEG; s++) begin
      vic_en[s] = wr_base_i
                | (wr_dbg_i && wr_seg_i == SEG_W'(s))
                | (fill_i && fill_seg_i == SEG_W'(s));
      vic_d[s]  = (fill_i && fill_seg_i == SEG_W'(s)) ? adv : vic_eff[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         base_q <= '0;
    else if (wr_base_i) base_q <= base_d;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         vic_q[s] <= '0;
      else if (vic_en[s]) vic_q[s] <= vic_d[s];
    end

    assert_vic_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vic_q[s] >= base_q);

    assert_rr_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_i && fill_seg_i == SEG_W'(s) && !wr_base_i && !wr_dbg_i && rr_mode_i
       && vic_q[s] != TOP_IX)
      |=> vic_q[s] == $past(vic_q[s]) + IDX_W'(1));

    assert_rr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_i && fill_seg_i == SEG_W'(s) && !wr_base_i && !wr_dbg_i && rr_mode_i
       && vic_q[s] == TOP_IX)
      |=> vic_q[s] == $past(base_q));

    assert_base_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_base_i && !(fill_i && fill_seg_i == SEG_W'(s)))
      |=> vic_q[s] == $past(wr_val_i));

    assert_other_seg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_base_i && !wr_dbg_i && fill_i && fill_seg_i != SEG_W'(s))
      |=> $stable(vic_q[s]));
  end

  assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_base_i |=> $stable(base_q));

  assert_victim_ge_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_i |-> victim_o >= base_d);

  assign base_o   = base_q;
  assign victim_o = cur;

endmodule

// File: rtl/lockdown_victim_sel.sv
module lockdown_victim_sel #(
  parameter int IDX_W   = 6,
  parameter int SEG_W   = 3,
  parameter int DATA_W  = 32,
  parameter int SEG_LSB = 5,
  parameter int LFSR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rr_mode,
  input  logic              reg_wr,
  input  logic              reg_dbg,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dfill,
  input  logic [SEG_W-1:0]  dfill_seg,
  output logic [IDX_W-1:0]  dvictim,
  input  logic              ifill,
  input  logic [SEG_W-1:0]  ifill_seg,
  output logic [IDX_W-1:0]  ivictim
);

  import lockdown_pkg::*;

  localparam int IDX_LSB = DATA_W - IDX_W;

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [LFSR_W-1:0] lfsr_state;
  lockdown_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .state_o(lfsr_state)
  );

  logic [IDX_W-1:0] wr_val;
  logic [SEG_W-1:0] wr_seg;
  assign wr_val = reg_wdata[DATA_W-1:IDX_LSB];
  assign wr_seg = reg_wdata[SEG_LSB+SEG_W-1:SEG_LSB];

  logic             fill_v   [NUM_CACHES];
  logic [SEG_W-1:0] fseg_v   [NUM_CACHES];
  logic [IDX_W-1:0] vic_v    [NUM_CACHES];
  logic [IDX_W-1:0] base_v   [NUM_CACHES];

  assign fill_v[CSEL_DATA] = dfill;
  assign fill_v[CSEL_INST] = ifill;
  assign fseg_v[CSEL_DATA] = dfill_seg;
  assign fseg_v[CSEL_INST] = ifill_seg;

  for (genvar c = 0; c < NUM_CACHES; c++) begin : g_cache
    logic sel_me;
    assign sel_me = reg_wr && (reg_sel == 1'(c));

    lockdown_ptr_bank #(.IDX_W(IDX_W), .SEG_W(SEG_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .rr_mode_i (rr_mode),
      .wr_base_i (sel_me && !reg_dbg),
      .wr_dbg_i  (sel_me && reg_dbg),
      .wr_val_i  (wr_val),
      .wr_seg_i  (wr_seg),
      .fill_i    (fill_v[c]),
      .fill_seg_i(fseg_v[c]),
      .rnd_i     (lfsr_state[IDX_W-1:0]),
      .base_o    (base_v[c]),
      .victim_o  (vic_v[c])
    );
  end

  assign dvictim   = vic_v[CSEL_DATA];
  assign ivictim   = vic_v[CSEL_INST];
  assign reg_rdata = {base_v[rd_sel], {IDX_LSB{1'b0}}};

  assert_rdata_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    reg_rdata[IDX_LSB-1:0] == '0);

endmodule

// File: tb/lockdown_victim_sel_tb.sv
`timescale 1ns/1ps
module lockdown_victim_sel_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rr_mode, reg_wr, reg_dbg, reg_sel, rd_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        dfill, ifill;
  logic [2:0]  dfill_seg, ifill_seg;
  logic [5:0]  dvictim, ivictim;

  int n_chk = 0, n_fail = 0;

  int  m_base  [2];
  int  m_vic   [2][8];
  bit  m_known [2][8];

  always #10 clk = ~clk;

  lockdown_victim_sel u_dut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .reg_wr(reg_wr), .reg_dbg(reg_dbg),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_sel(rd_sel), .reg_rdata(reg_rdata),
    .dfill(dfill), .dfill_seg(dfill_seg), .dvictim(dvictim),
    .ifill(ifill), .ifill_seg(ifill_seg), .ivictim(ivictim)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive on the falling edge, check 1 ns later, update the model
  task automatic step(input bit we, input bit dbg, input bit sel, input int val,
                      input int wseg, input bit df, input int dseg, input bit ifl,
                      input int iseg, input bit rr, input bit rsel, input string req);
    bit   fl [2];
    int   fs [2];
    int   act, exp, nb;
    @(negedge clk);
    reg_wr = we; reg_dbg = dbg; reg_sel = sel; rr_mode = rr; rd_sel = rsel;
    reg_wdata = {val[5:0], 18'b0, wseg[2:0], 5'b0};
    dfill = df; dfill_seg = dseg[2:0]; ifill = ifl; ifill_seg = iseg[2:0];
    fl[0] = df; fs[0] = dseg; fl[1] = ifl; fs[1] = iseg;
    #1;
    chk("R2 read base", int'(reg_rdata), m_base[rsel] << 26);
    for (int c = 0; c < 2; c++) begin
      // write effects (R3, R8)
      if (we && sel == c[0]) begin
        if (!dbg) begin
          m_base[c] = val;
          for (int s = 0; s < 8; s++) begin m_vic[c][s] = val; m_known[c][s] = 1; end
        end else begin
          m_vic[c][wseg] = (val < m_base[c]) ? m_base[c] : val;
          m_known[c][wseg] = 1;
        end
      end
      if (fl[c]) begin
        nb  = m_base[c];
        act = (c == 0) ? int'(dvictim) : int'(ivictim);
        if (m_known[c][fs[c]]) begin
          chk(req, act, m_vic[c][fs[c]]);
          exp = m_vic[c][fs[c]];
        end else begin
          chk("R6 R7 random victim in range", int'(act >= nb && act <= 63), 1);
          exp = act;
        end
        if (rr) begin
          m_vic[c][fs[c]] = (exp == 63) ? nb : exp + 1;
          m_known[c][fs[c]] = 1;
        end else begin
          m_known[c][fs[c]] = 0;
        end
      end
    end
  endtask

  task automatic idle_fill(input bit c, input int seg, input bit rr, input string req);
    if (c == 0) step(0, 0, 0, 0, 0, 1, seg, 0, 0, rr, 0, req);
    else        step(0, 0, 0, 0, 0, 0, 0, 1, seg, rr, 1, req);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bases [6] = '{0, 1, 3, 32, 62, 63};
    rst_n = 0; rr_mode = 1; reg_wr = 0; reg_dbg = 0; reg_sel = 0; rd_sel = 0;
    reg_wdata = '0; dfill = 0; ifill = 0; dfill_seg = '0; ifill_seg = '0;
    for (int c = 0; c < 2; c++) begin
      m_base[c] = 0;
      for (int s = 0; s < 8; s++) begin m_vic[c][s] = 0; m_known[c][s] = 1; end
    end
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset state on both read selects and on every segment's first fill
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R1 reset read");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R1 reset read");
    for (int s = 0; s < 8; s++) begin
      idle_fill(0, s, 1, "R1 reset victim");
      idle_fill(1, s, 1, "R1 reset victim");
    end

    // R3 R5 R7 R10: base sweep, round-robin over a full wrap
    for (int c = 0; c < 2; c++) begin
      foreach (bases[b]) begin
        int seg = b % 8;
        step(1, 0, c[0], bases[b], 0, 0, 0, 0, 0, 1, c[0], "R3 write");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, c[0], "R2 R3 read after write");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, !c[0], "R3 other cache untouched");
        for (int k = 0; k < 70; k++) idle_fill(c[0], seg, 1, "R4 R5 round-robin victim");
        idle_fill(c[0], (seg + 1) % 8, 1, "R10 other segment untouched");
      end
    end

    // R6 R7: random mode, base 20, then base 0
    step(1, 0, 0, 20, 0, 0, 0, 0, 0, 1, 0, "R3 write");
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, "R3 write");
    for (int k = 0; k < 300; k++) begin
      idle_fill(0, k % 8, 0, "R6 random victim");
      idle_fill(1, (k * 3) % 8, 0, "R6 random victim");
    end
    for (int k = 0; k < 16; k++) idle_fill(0, k % 8, 1, "R5 R6 after random");

    // R8: debug writes per segment, some below base
    step(1, 0, 0, 10, 0, 0, 0, 0, 0, 1, 0, "R3 write");
    for (int s = 0; s < 8; s++) begin
      step(1, 1, 0, s * 7, s, 0, 0, 0, 0, 1, 0, "R8 debug write");
      idle_fill(0, s, 1, "R8 debug victim");
      chk("R8 base unchanged", int'(reg_rdata >> 26), 10);
    end
    for (int s = 0; s < 8; s++) idle_fill(0, s, 1, "R8 R10 segment isolation");
    step(1, 1, 1, 50, 4, 0, 0, 0, 0, 1, 1, "R8 debug write");
    idle_fill(1, 4, 1, "R8 debug victim");
    idle_fill(1, 5, 1, "R8 other segment");

    // R9: write and fill in the same cycle
    step(1, 0, 0, 40, 0, 1, 2, 1, 2, 1, 0, "R9 write beats fill");
    idle_fill(0, 2, 1, "R9 advance from written");
    idle_fill(0, 3, 1, "R9 other segment written");
    step(1, 1, 1, 60, 6, 0, 0, 1, 6, 1, 1, "R9 debug write beats fill");
    idle_fill(1, 6, 1, "R9 advance from debug");
    step(1, 0, 1, 63, 0, 0, 0, 1, 1, 1, 1, "R9 R5 write 63 with fill");
    idle_fill(1, 1, 1, "R9 R5 wrap at top base");

    @(negedge clk);
    reg_wr = 0; dfill = 0; ifill = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule